// File: doc/BRIEF.md
# Exception Syndrome Register Updater

This block holds the 32-bit syndrome register that software reads after a synchronous interrupt to learn its cause. Bits are numbered 32 (the most significant) through 63. In this document "bit n" means architectural bit n, which sits at vector index 63 − n of the `syndrome` port.

When the core takes a program, alignment, data storage or data TLB error interrupt, it pulses `irq_take` with the interrupt kind. In that same cycle it presents the cause flags, the decoded cache-lock instruction class, the privilege mode and the user cache-lock enable. On the next clock edge the block replaces the whole register with a syndrome value built only from the bits that belong to that kind.

Between interrupts, software can read the register at any time on `syndrome` and can overwrite it through a one-cycle write port. The four reserved bits are always forced to zero. Detecting exceptions, vectoring and saving the return address are done elsewhere.

Top module: `fault_syndrome_reg`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads all zeros until the first update.
- R2: On a taken interrupt of kind 1 (program), bits 36, 37 and 38 take the illegal, privileged and trap flags on the next cycle.
- R3: On a taken interrupt of kind 2 (alignment), 3 (data storage) or 4 (data TLB error), bit 40 takes the store flag. On kind 1 it reads zero.
- R4: Bit 42 is set only by a kind 3 interrupt whose instruction is a data-cache lock operation, issued in user mode while user cache locking is disabled. Every other taken interrupt clears it.
- R5: Bit 43 is set only by a kind 3 interrupt whose instruction is an instruction-cache lock operation, issued in user mode while user cache locking is disabled. Every other taken interrupt clears it.
- R6: Reserved bits 39, 41, 44 and 45 always read zero, whatever is written.
- R7: A taken interrupt of kinds 1 to 4 clears every bit that does not belong to its kind, including bits left by software and cause flags that do not apply to it.
- R8: A strobe with kind 0, 5, 6 or 7 leaves the register unchanged.
- R9: A software write appears on the next cycle, with the reserved bits forced to zero.
- R10: When a software write and a taken interrupt of kinds 1 to 4 fall in the same cycle, the interrupt value is stored and the write data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_take | input | 1 | Interrupt-taken strobe |
| irq_kind | input | 3 | Interrupt kind: 1 program, 2 alignment, 3 data storage, 4 data TLB error, other codes ignored |
| cause_illegal | input | 1 | Illegal instruction cause |
| cause_priv | input | 1 | Privileged instruction cause |
| cause_trap | input | 1 | Trap cause |
| cause_store | input | 1 | Faulting access was a store |
| op_dcache_lock | input | 1 | Instruction is a data-cache touch-and-lock or lock-clear |
| op_icache_lock | input | 1 | Instruction is an instruction-cache touch-and-lock or lock-clear |
| mode_user | input | 1 | Core is in user (problem) state |
| ulock_enable | input | 1 | User-mode cache locking permitted |
| spr_we | input | 1 | Software write strobe |
| spr_wdata | input | 32 | Software write data, bit 32 at index 31 |
| syndrome | output | 32 | Current register value, bit 32 at index 31 |

## Verification
The bench builds the block with its default 32-bit register and 3-bit kind code. It therefore reaches every kind value, including the four unused codes that must be ignored. Directed steps cover each cause flag against each interrupt kind and every combination of the lock-qualifying inputs. They also cover all-ones writes against the reserved bits and a write that collides with an interrupt. A long random phase then mixes strobes, writes and kind codes, and compares every cycle against a behavioural model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam int SYN_W    = 32;
  localparam int BIT_BASE = 32;
  localparam int KIND_W   = 3;

  localparam logic [KIND_W-1:0] KIND_PROG  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_ALIGN = 3'd2;
  localparam logic [KIND_W-1:0] KIND_DSTOR = 3'd3;
  localparam logic [KIND_W-1:0] KIND_DTLB  = 3'd4;

  // architectural bit number -> vector index (bit 32 is the MSB)
  function automatic int pos(input int n);
    return SYN_W - 1 - (n - BIT_BASE);
  endfunction

  localparam int P_ILL  = pos(36);
  localparam int P_PRV  = pos(37);
  localparam int P_TRP  = pos(38);
  localparam int P_ST   = pos(40);
  localparam int P_DLK  = pos(42);
  localparam int P_ILK  = pos(43);
  localparam int P_R39  = pos(39);
  localparam int P_R41  = pos(41);
  localparam int P_R44  = pos(44);
  localparam int P_R45  = pos(45);

  localparam logic [SYN_W-1:0] ONE = SYN_W'(1);

  localparam logic [SYN_W-1:0] RSVD_MASK =
    (ONE << P_R39) | (ONE << P_R41) | (ONE << P_R44) | (ONE << P_R45);

  localparam logic [SYN_W-1:0] PROG_MASK =
    (ONE << P_ILL) | (ONE << P_PRV) | (ONE << P_TRP);

  localparam logic [SYN_W-1:0] CAUSE_MASK =
    PROG_MASK | (ONE << P_ST) | (ONE << P_DLK) | (ONE << P_ILK);

  typedef struct packed {
    logic illegal;
    logic privileged;
    logic trap;
    logic store;
    logic dlock_fault;
    logic ilock_fault;
  } cause_t;

endpackage

// File: rtl/fsr_rst_sync.sv
module fsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fsr_lock_qual.sv
module fsr_lock_qual (
  input  logic op_dcache_lock,
  input  logic op_icache_lock,
  input  logic mode_user,
  input  logic ulock_enable,
  output logic dlock_fault,
  output logic ilock_fault
);
  logic user_lock_denied;

  always_comb begin
    user_lock_denied = mode_user & ~ulock_enable;
    dlock_fault      = op_dcache_lock & user_lock_denied;
    ilock_fault      = op_icache_lock & user_lock_denied;
  end
endmodule

// File: rtl/fsr_cause_enc.sv
module fsr_cause_enc
  import fsr_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  cause_t            cause,
  output logic              hit,
  output logic [SYN_W-1:0]  syn_new
);
  always_comb begin
    hit     = 1'b0;
    syn_new = '0;
    unique case (kind)
      KIND_PROG: begin
        hit            = 1'b1;
        syn_new[P_ILL] = cause.illegal;
        syn_new[P_PRV] = cause.privileged;
        syn_new[P_TRP] = cause.trap;
      end
      KIND_ALIGN, KIND_DTLB: begin
        hit           = 1'b1;
        syn_new[P_ST] = cause.store;
      end
      KIND_DSTOR: begin
        hit            = 1'b1;
        syn_new[P_ST]  = cause.store;
        syn_new[P_DLK] = cause.dlock_fault;
        syn_new[P_ILK] = cause.ilock_fault;
      end
      default: begin
        hit     = 1'b0;
        syn_new = '0;
      end
    endcase
  end
endmodule

// File: rtl/fsr_sw_mask.sv
module fsr_sw_mask
  import fsr_pkg::*;
(
  input  logic [SYN_W-1:0] wdata,
  output logic [SYN_W-1:0] wdata_clean
);
  for (genvar i = 0; i < SYN_W; i++) begin : g_bit
    if (RSVD_MASK[i]) begin : g_rsvd
      assign wdata_clean[i] = 1'b0;
    end else begin : g_keep
      assign wdata_clean[i] = wdata[i];
    end
  end
endmodule

// File: rtl/fault_syndrome_reg.sv
module fault_syndrome_reg
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_take,
  input  logic [KIND_W-1:0] irq_kind,
  input  logic              cause_illegal,
  input  logic              cause_priv,
  input  logic              cause_trap,
  input  logic              cause_store,
  input  logic              op_dcache_lock,
  input  logic              op_icache_lock,
  input  logic              mode_user,
  input  logic              ulock_enable,
  input  logic              spr_we,
  input  logic [SYN_W-1:0]  spr_wdata,
  output logic [SYN_W-1:0]  syndrome
);
  logic             rst_sync_n;
  logic             dlock_fault;
  logic             ilock_fault;
  cause_t           cause;
  logic             enc_hit;
  logic [SYN_W-1:0] enc_syn;
  logic [SYN_W-1:0] wr_clean;
  logic [SYN_W-1:0] syn_q;
  logic [SYN_W-1:0] syn_d;
  logic             syn_en;

  fsr_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsr_lock_qual i_lock_qual (
    .op_dcache_lock (op_dcache_lock),
    .op_icache_lock (op_icache_lock),
    .mode_user      (mode_user),
    .ulock_enable   (ulock_enable),
    .dlock_fault    (dlock_fault),
    .ilock_fault    (ilock_fault)
  );

  always_comb begin
    cause.illegal     = cause_illegal;
    cause.privileged  = cause_priv;
    cause.trap        = cause_trap;
    cause.store       = cause_store;
    cause.dlock_fault = dlock_fault;
    cause.ilock_fault = ilock_fault;
  end

  fsr_cause_enc i_cause_enc (
    .kind    (irq_kind),
    .cause   (cause),
    .hit     (enc_hit),
    .syn_new (enc_syn)
  );

  fsr_sw_mask i_sw_mask (
    .wdata       (spr_wdata),
    .wdata_clean (wr_clean)
  );

  // next state: interrupt update has priority over a software write
  always_comb begin
    syn_d  = syn_q;
    syn_en = 1'b0;
    if (irq_take && enc_hit) begin
      syn_d  = enc_syn;
      syn_en = 1'b1;
    end else if (spr_we) begin
      syn_d  = wr_clean;
      syn_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  syn_q <= '0;
    else if (syn_en)  syn_q <= syn_d;
  end

  assign syndrome = syn_q;
endmodule

// File: rtl/fsr_sva.sv
module fsr_sva
  import fsr_pkg::*;
(
  input logic              clk,
  input logic              rst_ok_n,
  input logic              irq_take,
  input logic [KIND_W-1:0] irq_kind,
  input logic              cause_illegal,
  input logic              cause_priv,
  input logic              cause_trap,
  input logic              cause_store,
  input logic              op_dcache_lock,
  input logic              op_icache_lock,
  input logic              mode_user,
  input logic              ulock_enable,
  input logic              spr_we,
  input logic [SYN_W-1:0]  spr_wdata,
  input logic [SYN_W-1:0]  syndrome
);
  logic kind_ok;
  logic data_kind;
  assign kind_ok   = (irq_kind >= KIND_PROG) && (irq_kind <= KIND_DTLB);
  assign data_kind = (irq_kind == KIND_ALIGN) || (irq_kind == KIND_DSTOR) ||
                     (irq_kind == KIND_DTLB);

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_ok_n |=> (syndrome == '0));

  p_prog_causes_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    irq_take && irq_kind == KIND_PROG |=>
      syndrome[P_ILL] == $past(cause_illegal) &&
      syndrome[P_PRV] == $past(cause_priv) &&
      syndrome[P_TRP] == $past(cause_trap));

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    irq_take && data_kind |=> syndrome[P_ST] == $past(cause_store));

  p_dlock_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    irq_take && kind_ok |=>
      syndrome[P_DLK] == $past(irq_kind == KIND_DSTOR && op_dcache_lock &&
                               mode_user && !ulock_enable));

  p_ilock_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    irq_take && kind_ok |=>
      syndrome[P_ILK] == $past(irq_kind == KIND_DSTOR && op_icache_lock &&
                               mode_user && !ulock_enable));

  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (syndrome & RSVD_MASK) == '0);

  p_prog_clears_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    irq_take && irq_kind == KIND_PROG |=> (syndrome & ~PROG_MASK) == '0);

  p_other_kind_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    irq_take && !kind_ok && !spr_we |=> $stable(syndrome));

  p_sw_write_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    spr_we && !(irq_take && kind_ok) |=>
      syndrome == ($past(spr_wdata) & ~RSVD_MASK));

  p_irq_wins_r10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    spr_we && irq_take && kind_ok |=> (syndrome & ~CAUSE_MASK) == '0);
endmodule

bind fault_syndrome_reg fsr_sva i_fsr_sva (
  .clk            (clk),
  .rst_ok_n       (rst_sync_n),
  .irq_take       (irq_take),
  .irq_kind       (irq_kind),
  .cause_illegal  (cause_illegal),
  .cause_priv     (cause_priv),
  .cause_trap     (cause_trap),
  .cause_store    (cause_store),
  .op_dcache_lock (op_dcache_lock),
  .op_icache_lock (op_icache_lock),
  .mode_user      (mode_user),
  .ulock_enable   (ulock_enable),
  .spr_we         (spr_we),
  .spr_wdata      (spr_wdata),
  .syndrome       (syndrome)
);

// File: tb/test_fault_syndrome_reg.sv
`timescale 1ns/1ps
module test_fault_syndrome_reg;
  logic        clk;
  logic        rst_n;
  logic        irq_take;
  logic [2:0]  irq_kind;
  logic        cause_illegal, cause_priv, cause_trap, cause_store;
  logic        op_dcache_lock, op_icache_lock, mode_user, ulock_enable;
  logic        spr_we;
  logic [31:0] spr_wdata;
  logic [31:0] syndrome;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model = '0;

  fault_syndrome_reg i_fault_syndrome_reg (
    .clk(clk), .rst_n(rst_n), .irq_take(irq_take), .irq_kind(irq_kind),
    .cause_illegal(cause_illegal), .cause_priv(cause_priv),
    .cause_trap(cause_trap), .cause_store(cause_store),
    .op_dcache_lock(op_dcache_lock), .op_icache_lock(op_icache_lock),
    .mode_user(mode_user), .ulock_enable(ulock_enable),
    .spr_we(spr_we), .spr_wdata(spr_wdata), .syndrome(syndrome)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] bitn(input int n);
    return 32'h1 << (63 - n);
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] cur);
    logic [31:0] v;
    bit denied;
    denied = mode_user && !ulock_enable;
    if (irq_take && irq_kind >= 1 && irq_kind <= 4) begin
      v = '0;
      if (irq_kind == 1) begin
        if (cause_illegal) v |= bitn(36);
        if (cause_priv)    v |= bitn(37);
        if (cause_trap)    v |= bitn(38);
      end else begin
        if (cause_store) v |= bitn(40);
        if (irq_kind == 3 && denied && op_dcache_lock) v |= bitn(42);
        if (irq_kind == 3 && denied && op_icache_lock) v |= bitn(43);
      end
      return v;
    end
    if (spr_we)
      return spr_wdata & ~(bitn(39) | bitn(41) | bitn(44) | bitn(45));
    return cur;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (syndrome !== model) begin
      fails++;
      $display("FAIL %s: syndrome=%h expected=%h", tag, syndrome, model);
    end
  endtask

  task automatic idle_inputs();
    irq_take = 0; irq_kind = 0; cause_illegal = 0; cause_priv = 0;
    cause_trap = 0; cause_store = 0; op_dcache_lock = 0; op_icache_lock = 0;
    mode_user = 0; ulock_enable = 0; spr_we = 0; spr_wdata = '0;
  endtask

  // inputs already driven; clock one edge, update model, compare at negedge
  task automatic tick(input string tag);
    logic [31:0] nxt;
    nxt = ref_next(model);
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    check(tag);
    idle_inputs();
  endtask

  task automatic irq(input logic [2:0] k, input logic [5:0] c,
                     input bit user, input bit ule, input string tag);
    irq_take = 1; irq_kind = k;
    {cause_illegal, cause_priv, cause_trap, cause_store,
     op_dcache_lock, op_icache_lock} = c;
    mode_user = user; ulock_enable = ule;
    tick(tag);
  endtask

  task automatic swr(input logic [31:0] d, input string tag);
    spr_we = 1; spr_wdata = d;
    tick(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: syndrome=%h expected=%h", syndrome, model);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after release");

    // R2: program causes
    irq(3'd1, 6'b100000, 0, 0, "R2 illegal");
    irq(3'd1, 6'b010000, 0, 0, "R2 privileged");
    irq(3'd1, 6'b001000, 0, 0, "R2 trap");
    irq(3'd1, 6'b111111, 1, 0, "R3 store ignored on program");
    // R3: store on data kinds
    irq(3'd2, 6'b000100, 0, 0, "R3 alignment store");
    irq(3'd4, 6'b000100, 0, 0, "R3 dtlb store");
    irq(3'd3, 6'b111100, 0, 0, "R7 program causes ignored on data storage");
    // R4/R5 lock qualification
    irq(3'd3, 6'b000010, 1, 0, "R4 dcache lock user denied");
    irq(3'd3, 6'b000010, 1, 1, "R4 lock enabled no bit");
    irq(3'd3, 6'b000010, 0, 0, "R4 supervisor no bit");
    irq(3'd2, 6'b000011, 1, 0, "R4 alignment no lock bit");
    irq(3'd3, 6'b000001, 1, 0, "R5 icache lock user denied");
    irq(3'd3, 6'b000001, 0, 1, "R5 supervisor enabled no bit");
    irq(3'd4, 6'b000011, 1, 0, "R5 dtlb no lock bit");
    irq(3'd3, 6'b000111, 1, 0, "R5 both lock bits and store");
    // R9/R6 software writes
    swr(32'hFFFF_FFFF, "R6 all ones write");
    swr(32'h1234_5678, "R9 pattern write");
    // R8 ignored kinds
    for (int k = 0; k < 8; k++) begin
      if (k >= 1 && k <= 4) continue;
      irq(k[2:0], 6'b111111, 1, 0, "R8 unused kind holds");
    end
    // R7 interrupt clears software bits
    swr(32'hFFFF_FFFF, "R9 refill");
    irq(3'd2, 6'b000000, 0, 0, "R7 clears software bits");
    // R10 collision
    spr_we = 1; spr_wdata = 32'hFFFF_FFFF;
    irq(3'd1, 6'b100000, 0, 0, "R10 interrupt wins");
    spr_we = 1; spr_wdata = 32'hA5A5_A5A5;
    irq(3'd6, 6'b111111, 1, 0, "R10 unused kind lets write through");

    // random mix
    for (int i = 0; i < 400; i++) begin
      irq_take       = $urandom_range(0, 1);
      irq_kind       = 3'($urandom_range(0, 7));
      {cause_illegal, cause_priv, cause_trap, cause_store} = 4'($urandom);
      {op_dcache_lock, op_icache_lock, mode_user, ulock_enable} = 4'($urandom);
      spr_we         = ($urandom_range(0, 3) == 0);
      spr_wdata      = $urandom;
      tick("R7 random mix");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule